// File: doc/BRIEF.md
# Per-Bit Soft Output Generator for QPSK Symbol Decisions

This block turns the three best surviving path metrics of a sequence detector into one signed reliability value per bit of a QPSK symbol. The three metrics arrive already sorted, smallest first, and each metric comes with the 2-bit symbol decision of its path. For each of the two bits on its own, the block measures how far the winning path is from the nearest listed path that decided that bit the other way. That metric gap becomes the magnitude of the output, and the winning path's bit decision sets its sign.

Results are held in sign-magnitude form inside the block. They are offered on two output buses: one in sign-magnitude form and one converted to two's complement at the output. Input and output are valid/ready streams with one register stage between them. A transfer happens on a rising clock edge when valid and ready are both high. The upstream side may hold `in_valid` high for as long as it likes. The block raises `in_ready` whenever its output register is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, the output register and both output buses hold their values and no new symbol is accepted. The metric width must be at least the magnitude width.

Top module: `llr_gen`

## Requirements
- R1: For bit b (b = 0 is bit 0 of each `dec_in` entry, b = 1 is bit 1), when `dec_in[0][b]` differs from `dec_in[1][b]`, the magnitude is `pm_in[1] - pm_in[0]`.
- R2: When `dec_in[0][b]` equals `dec_in[1][b]` but differs from `dec_in[2][b]`, the magnitude is `pm_in[2] - pm_in[0]`.
- R3: A metric difference larger than 2^MAG_W - 1 (127 by default) gives the magnitude 2^MAG_W - 1.
- R4: A difference whose subtrahend is larger than its minuend (metrics not sorted) gives the magnitude 0.
- R5: The sign bit `llr_sm[b][MAG_W]` equals `dec_in[0][b]`, so a decision of 0 gives a positive value and 1 gives a negative value.
- R6: `llr_tc[b]` is the two's complement value of `llr_sm[b]`: +magnitude when the sign bit is 0, -magnitude when it is 1.
- R7: A symbol accepted on a clock edge appears with `out_valid` high right after that same edge, so the latency is one cycle.
- R8: `in_ready` is high exactly when `out_valid` is low or `out_ready` is high. While `out_valid` is high and `out_ready` is low, `out_valid`, `llr_sm` and `llr_tc` stay unchanged on the next cycle.
- R9: While `rst_n` is low, `out_valid` is low and `in_ready` is high.
- R10: Each bit is evaluated independently. Bit 1 uses only bit 1 of the three decisions, even when bit 0 selects the other difference.
- R11: When all three decisions agree on bit b, no listed competitor exists and the magnitude is 2^MAG_W - 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input symbol is present |
| in_ready | output | 1 | Block can take a symbol this cycle |
| pm_in | input | 3 x PM_W | Sorted path metrics, entry 0 the smallest |
| dec_in | input | 3 x 2 | Symbol decision of each path, same order |
| out_valid | output | 1 | Output symbol is present |
| out_ready | input | 1 | Downstream takes the output this cycle |
| llr_sm | output | 2 x (MAG_W+1) | Sign-magnitude value per bit, sign in the top bit |
| llr_tc | output | 2 x (MAG_W+1) | Two's complement value per bit |

## Verification
The state in this block is the output register and its valid flag. A fault in the valid flag shows at the ports on the first stalled or idle cycle, as a dropped, repeated or invented symbol, or as an `in_ready` that breaks the back-pressure rule. A wrong captured value shows on the very next transfer after the bad symbol is accepted, either as a magnitude from the wrong difference or as a flipped sign. Stalls of random length check that the held value does not drift while `out_ready` is low. Directed symbols cover saturation, unsorted metrics and decisions where all three paths agree.

// File: rtl/llr_pkg.sv
package llr_pkg;
  // QPSK: two bits per symbol, three ranked paths considered
  localparam int NBIT  = 2;
  localparam int NPATH = 3;

  // index names for the ranked paths
  localparam int P_WIN = 0;
  localparam int P_RUN = 1;
  localparam int P_THR = 2;
endpackage

// File: rtl/llr_metric_diff.sv
module llr_metric_diff #(
  parameter int PM_W  = 10,
  parameter int MAG_W = 7
) (
  input  logic [llr_pkg::NPATH-1:0][PM_W-1:0] pm,
  output logic [llr_pkg::NPATH-2:0][MAG_W-1:0] gap
);
  localparam logic [PM_W-1:0] SAT = PM_W'((1 << MAG_W) - 1);

  // gap[k-1] = pm[k] - pm[0], floored at zero and clipped to the magnitude range
  for (genvar k = 1; k < llr_pkg::NPATH; k++) begin : g_gap
    logic [PM_W-1:0] raw;
    always_comb begin
      raw = pm[k] - pm[llr_pkg::P_WIN];
      if (pm[k] < pm[llr_pkg::P_WIN]) begin
        gap[k-1] = '0;
      end else if (raw > SAT) begin
        gap[k-1] = SAT[MAG_W-1:0];
      end else begin
        gap[k-1] = raw[MAG_W-1:0];
      end
    end
  end
endmodule

// File: rtl/llr_bit_pick.sv
module llr_bit_pick #(
  parameter int MAG_W = 7
) (
  input  logic             win_bit,
  input  logic             run_bit,
  input  logic             thr_bit,
  input  logic [MAG_W-1:0] gap_run,
  input  logic [MAG_W-1:0] gap_thr,
  output logic [MAG_W:0]   sm
);
  logic [MAG_W-1:0] mag;

  always_comb begin
    if (win_bit != run_bit) begin
      mag = gap_run;
    end else if (win_bit != thr_bit) begin
      mag = gap_thr;
    end else begin
      mag = '1;
    end
    sm = {win_bit, mag};
  end
endmodule

// File: rtl/llr_sm2tc.sv
module llr_sm2tc #(
  parameter int MAG_W = 7
) (
  input  logic [MAG_W:0] sm,
  output logic [MAG_W:0] tc
);
  logic [MAG_W:0] pos;

  always_comb begin
    pos = {1'b0, sm[MAG_W-1:0]};
    tc  = sm[MAG_W] ? (~pos + 1'b1) : pos;
  end
endmodule

// File: rtl/llr_gen.sv
module llr_gen #(
  parameter int PM_W  = 10,
  parameter int MAG_W = 7
) (
  input  logic                                          clk,
  input  logic                                          rst_n,
  input  logic                                          in_valid,
  output logic                                          in_ready,
  input  logic [llr_pkg::NPATH-1:0][PM_W-1:0]           pm_in,
  input  logic [llr_pkg::NPATH-1:0][llr_pkg::NBIT-1:0]  dec_in,
  output logic                                          out_valid,
  input  logic                                          out_ready,
  output logic [llr_pkg::NBIT-1:0][MAG_W:0]             llr_sm,
  output logic [llr_pkg::NBIT-1:0][MAG_W:0]             llr_tc
);
  import llr_pkg::*;

  logic [NPATH-2:0][MAG_W-1:0] gap;
  logic [NBIT-1:0][MAG_W:0]    sm_d;
  logic [NBIT-1:0][MAG_W:0]    sm_q;
  logic                        vld_q;
  logic                        take;

  llr_metric_diff #(.PM_W(PM_W), .MAG_W(MAG_W)) diff_i (
    .pm  (pm_in),
    .gap (gap)
  );

  for (genvar b = 0; b < NBIT; b++) begin : g_bit
    llr_bit_pick #(.MAG_W(MAG_W)) pick_i (
      .win_bit (dec_in[P_WIN][b]),
      .run_bit (dec_in[P_RUN][b]),
      .thr_bit (dec_in[P_THR][b]),
      .gap_run (gap[0]),
      .gap_thr (gap[1]),
      .sm      (sm_d[b])
    );

    llr_sm2tc #(.MAG_W(MAG_W)) fmt_i (
      .sm (sm_q[b]),
      .tc (llr_tc[b])
    );
  end

  assign in_ready = !vld_q || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      sm_q  <= '0;
    end else begin
      if (in_ready) vld_q <= in_valid;
      if (take)     sm_q  <= sm_d;
    end
  end

  assign out_valid = vld_q;
  assign llr_sm    = sm_q;
endmodule

// File: rtl/llr_gen_chk.sv
module llr_gen_chk #(
  parameter int PM_W  = 10,
  parameter int MAG_W = 7
) (
  input logic                                          clk,
  input logic                                          rst_n,
  input logic                                          in_valid,
  input logic                                          in_ready,
  input logic [llr_pkg::NPATH-1:0][PM_W-1:0]           pm_in,
  input logic [llr_pkg::NPATH-1:0][llr_pkg::NBIT-1:0]  dec_in,
  input logic                                          out_valid,
  input logic                                          out_ready,
  input logic [llr_pkg::NBIT-1:0][MAG_W:0]             llr_sm,
  input logic [llr_pkg::NBIT-1:0][MAG_W:0]             llr_tc
);
  localparam int MAXV = (1 << MAG_W) - 1;

  logic            acc;
  logic [PM_W-1:0] d1, d2;
  logic            ok1, ok2, big1;
  assign acc  = in_valid && in_ready;
  assign d1   = pm_in[1] - pm_in[0];
  assign d2   = pm_in[2] - pm_in[0];
  assign ok1  = (pm_in[1] >= pm_in[0]) && (int'(d1) <= MAXV);
  assign ok2  = (pm_in[2] >= pm_in[0]) && (int'(d2) <= MAXV);
  assign big1 = (pm_in[1] >= pm_in[0]) && (int'(d1) > MAXV);

  assert_reset_R9: assert property (@(posedge clk) !rst_n |=> !out_valid);

  assert_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready == (!out_valid || out_ready));

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(llr_sm) && $stable(llr_tc)));

  assert_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> out_valid);

  for (genvar b = 0; b < llr_pkg::NBIT; b++) begin : g_b
    logic [MAG_W:0] neg;
    assign neg = ~{1'b0, llr_sm[b][MAG_W-1:0]} + 1'b1;

    assert_tc_R6: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (llr_tc[b] == (llr_sm[b][MAG_W] ? neg : {1'b0, llr_sm[b][MAG_W-1:0]})));

    assert_sign_R5: assert property (@(posedge clk) disable iff (!rst_n)
      acc |=> (llr_sm[b][MAG_W] == $past(dec_in[0][b])));

    assert_pick_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && ok1 && (dec_in[0][b] != dec_in[1][b]))
      |=> (llr_sm[b][MAG_W-1:0] == $past(d1[MAG_W-1:0])));

    assert_pick_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && ok2 && (dec_in[0][b] == dec_in[1][b]) && (dec_in[0][b] != dec_in[2][b]))
      |=> (llr_sm[b][MAG_W-1:0] == $past(d2[MAG_W-1:0])));

    assert_sat_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && big1 && (dec_in[0][b] != dec_in[1][b])) |=> (&llr_sm[b][MAG_W-1:0]));

    assert_floor_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && (pm_in[1] < pm_in[0]) && (dec_in[0][b] != dec_in[1][b]))
      |=> (llr_sm[b][MAG_W-1:0] == '0));

    assert_agree_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && (dec_in[0][b] == dec_in[1][b]) && (dec_in[0][b] == dec_in[2][b]))
      |=> (&llr_sm[b][MAG_W-1:0]));
  end
endmodule

bind llr_gen llr_gen_chk #(.PM_W(PM_W), .MAG_W(MAG_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .pm_in     (pm_in),
  .dec_in    (dec_in),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .llr_sm    (llr_sm),
  .llr_tc    (llr_tc)
);

// File: tb/llr_gen_tb_top.sv
module llr_gen_tb_top;
  localparam int PM_W  = 10;
  localparam int MAG_W = 7;
  localparam int MAXV  = (1 << MAG_W) - 1;

  logic                  clk = 1'b0;
  logic                  rst_n = 1'b0;
  logic                  in_valid = 1'b0;
  logic                  in_ready;
  logic [2:0][PM_W-1:0]  pm_in = '0;
  logic [2:0][1:0]       dec_in = '0;
  logic                  out_valid;
  logic                  out_ready = 1'b0;
  logic [1:0][MAG_W:0]   llr_sm;
  logic [1:0][MAG_W:0]   llr_tc;

  int tests = 0;
  int fails = 0;

  typedef struct packed {
    logic [1:0][MAG_W:0] sm;
    logic [1:0][7:0]     tag;   // requirement number per bit
  } exp_t;

  exp_t q[$];
  logic                prev_stall = 1'b0;
  logic                prev_acc   = 1'b0;
  logic [1:0][MAG_W:0] prev_sm    = '0;

  always #5 clk = ~clk;

  llr_gen #(.PM_W(PM_W), .MAG_W(MAG_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .pm_in(pm_in), .dec_in(dec_in), .out_valid(out_valid),
    .out_ready(out_ready), .llr_sm(llr_sm), .llr_tc(llr_tc)
  );

  function automatic int gap(input int a, input int b);
    if (a < b) return 0;
    if (a - b > MAXV) return MAXV;
    return a - b;
  endfunction

  function automatic exp_t model(input logic [2:0][PM_W-1:0] p, input logic [2:0][1:0] d);
    exp_t e;
    for (int b = 0; b < 2; b++) begin
      int m; int t;
      if (d[0][b] != d[1][b]) begin
        m = gap(int'(p[1]), int'(p[0])); t = 1;
        if (p[1] < p[0]) t = 4; else if (int'(p[1]) - int'(p[0]) > MAXV) t = 3;
      end else if (d[0][b] != d[2][b]) begin
        m = gap(int'(p[2]), int'(p[0])); t = 2;
        if (p[2] < p[0]) t = 4; else if (int'(p[2]) - int'(p[0]) > MAXV) t = 3;
      end else begin
        m = MAXV; t = 11;
      end
      e.sm[b]  = {d[0][b], m[MAG_W-1:0]};
      e.tag[b] = 8'(t);
    end
    return e;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cycle(input bit v, input logic [2:0][PM_W-1:0] p,
                       input logic [2:0][1:0] d, input bit rdy);
    @(negedge clk);
    in_valid = v; pm_in = p; dec_in = d; out_ready = rdy;
    #1;
    check(in_ready == (!out_valid || out_ready), "R8 ready rule", in_ready, !out_valid || out_ready);
    if (prev_stall) check(out_valid && llr_sm == prev_sm, "R8 hold", llr_sm, prev_sm);
    if (prev_acc)   check(out_valid, "R7 latency", out_valid, 1);
    if (out_valid && out_ready) begin
      if (q.size() == 0) check(1'b0, "R8 extra output", 1, 0);
      else begin
        exp_t e = q.pop_front();
        for (int b = 0; b < 2; b++) begin
          int em = int'(e.sm[b][MAG_W-1:0]);
          int am = int'(llr_sm[b][MAG_W-1:0]);
          int et = e.sm[b][MAG_W] ? -em : em;
          int at = int'($signed(llr_tc[b]));
          string r = $sformatf("%sR%0d mag", (b == 1) ? "R10 " : "", e.tag[b]);
          check(am == em, r, am, em);
          check(llr_sm[b][MAG_W] == e.sm[b][MAG_W], "R5 sign", llr_sm[b][MAG_W], e.sm[b][MAG_W]);
          check(at == et, "R6 twos complement", at, et);
        end
      end
    end
    prev_acc = in_valid && in_ready;
    if (prev_acc) q.push_back(model(pm_in, dec_in));
    prev_stall = out_valid && !out_ready;
    prev_sm    = llr_sm;
  endtask

  function automatic logic [2:0][PM_W-1:0] pms(input int a, input int b, input int c);
    return {PM_W'(c), PM_W'(b), PM_W'(a)};
  endfunction

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check(!out_valid, "R9 reset valid", out_valid, 0);
    check(in_ready, "R9 reset ready", in_ready, 1);
    @(negedge clk); rst_n = 1'b1;

    // directed corners: decisions ordered {path2, path1, path0}
    cycle(1, pms(100, 130, 150), {2'b00, 2'b11, 2'b00}, 1);   // R1 both bits
    cycle(1, pms(100, 130, 150), {2'b11, 2'b00, 2'b00}, 1);   // R2 both bits
    cycle(1, pms(100, 130, 150), {2'b10, 2'b01, 2'b00}, 1);   // R10 mixed
    cycle(1, pms(0, 1023, 1023), {2'b11, 2'b11, 2'b00}, 1);   // R3
    cycle(1, pms(500, 400, 300), {2'b01, 2'b10, 2'b01}, 1);   // R4
    cycle(1, pms(10, 20, 30), {2'b10, 2'b10, 2'b10}, 1);      // R11 / R5 negative
    cycle(1, pms(5, 5, 5), {2'b00, 2'b11, 2'b00}, 0);         // zero gap, then stall
    cycle(1, pms(7, 8, 9), {2'b01, 2'b10, 2'b11}, 0);
    cycle(1, pms(7, 8, 9), {2'b01, 2'b10, 2'b11}, 1);
    cycle(0, '0, '0, 1);

    for (int i = 0; i < 4000; i++) begin
      int a = int'($urandom % 900);
      int b = a + int'($urandom % 160);
      int c = b + int'($urandom % 160);
      if ($urandom % 16 == 0) b = int'($urandom % 1024);
      if (b > 1023) b = 1023;
      if (c > 1023) c = 1023;
      cycle(($urandom % 4) != 0, pms(a, b, c), 6'($urandom), ($urandom % 3) != 0);
    end
    repeat (3) cycle(0, '0, '0, 1);
    check(q.size() == 0, "R7 drained", q.size(), 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule